// File: doc/BRIEF.md
# Key-Guarded Indexed Configuration Register Bank

This block holds a chipset's byte-wide configuration registers behind two addresses on an 8-bit host I/O bus. A write to the index address picks one of 256 registers. Reads and writes at the data address then reach the picked register. Stores are refused until a key value has been written through a reserved index. While unlocked, each stored byte is trimmed by a mask that belongs to its register. A few registers cannot be written at all, and one register only ever gains bits.

Every register is driven out in parallel so that neighbouring decode logic can use its contents directly. A one-cycle change pulse that carries the register's index tells that logic when it should recompute. Reset loads a fixed set of power-up values.

Top module: `cfgkey_regfile`

## Requirements
- R1: A bus write to address 22h loads the index from the write data. A bus read of 22h returns the index on busRdata in the cycle after the read strobe.
- R2: A bus read of address 23h returns the register that the index selects, on busRdata in the cycle after the read strobe.
- R3: A data write while the index is 13h sets the unlocked state when the value is C5h and clears it for any other value. Register 13h is never stored and always reads 00h.
- R4: While the block is locked, data writes to every index other than 13h leave all registers unchanged.
- R5: Registers 30h, 34h, 35h, 3Eh, 3Fh, 46h, 4Ch, 6Ah and 73h ignore data writes even while the block is unlocked.
- R6: An accepted write stores the value ANDed with that register's mask: 1Eh=07h, 12h=F7h, 20h=BFh, 31h=21h, 32h=C1h, 3Ch=8Fh, 44h=3Fh, 45h=3Fh. Every other writable register has mask FFh.
- R7: A write to register 36h ORs the upper nibble of the value into the current contents. Bits that are already set stay set, and the lower nibble never changes.
- R8: Reset sets every register to 00h except 11h=F8h, 12h=20h, 17h=FFh, 18h=F0h, 1Ah=FFh, 1Bh=F0h, 1Dh=FFh and 20h=80h. Reset also clears the unlocked state and sets the index to 00h.
- R9: When an accepted write changes a register, chgValid is high for exactly the following cycle and chgIndex names that register. A write that leaves the value the same, or that is refused, gives no pulse.
- R10: regsFlat bits [8n+7:8n] always show register n. A stored write shows up there in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | I/O address of the access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered |
| regsFlat | output | 2048 | All 256 registers concatenated, register n at [8n+7:8n] |
| chgValid | output | 1 | One-cycle pulse after a register changes |
| chgIndex | output | 8 | Index of the register that changed |

## Verification
The lock state cannot be read directly. If it is wrong, it shows up on the first data write after a key write: regsFlat either changes when it should stay put or stays put when it should change, one cycle after the strobe. A wrong mask, a wrong read-only decode or a lost sticky bit shows on regsFlat in that same cycle. A corrupted index shows one cycle after the next read of either port. Because regsFlat is compared in full after every access, a bad store is caught the moment it happens and does not wait for a later read to expose it.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;
  localparam int IDX_W = 8;
  localparam int DATA_W = 8;
  localparam int REG_COUNT = 1 << IDX_W;
  localparam int FLAT_W = REG_COUNT * DATA_W;

  localparam logic [IDX_W-1:0] STICKY_IDX = 8'h36;

  typedef struct packed {
    logic              regWr;
    logic [IDX_W-1:0]  regIdx;
    logic [DATA_W-1:0] wdata;
    logic              rdIdx;
    logic              rdData;
    logic [IDX_W-1:0]  curIdx;
  } cfgStrobe_t;

  function automatic logic isReadOnly(input logic [IDX_W-1:0] idx);
    case (idx)
      8'h30, 8'h34, 8'h35, 8'h3E, 8'h3F, 8'h46, 8'h4C, 8'h6A, 8'h73: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] writeMask(input logic [IDX_W-1:0] idx);
    case (idx)
      8'h1E: return 8'h07;
      8'h12: return 8'hF7;
      8'h20: return 8'hBF;
      8'h31: return 8'h21;
      8'h32: return 8'hC1;
      8'h3C: return 8'h8F;
      8'h44, 8'h45: return 8'h3F;
      8'h36: return 8'hF0;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetValue(input logic [IDX_W-1:0] idx);
    case (idx)
      8'h11: return 8'hF8;
      8'h12: return 8'h20;
      8'h17, 8'h1A, 8'h1D: return 8'hFF;
      8'h18, 8'h1B: return 8'hF0;
      8'h20: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] mergeWrite(input logic [IDX_W-1:0] idx,
                                                   input logic [DATA_W-1:0] cur,
                                                   input logic [DATA_W-1:0] wdata);
    if (idx == STICKY_IDX) return cur | (wdata & writeMask(idx));
    return wdata & writeMask(idx);
  endfunction
endpackage

// File: rtl/cfgkey_ctrl.sv
module cfgkey_ctrl
  import cfgkey_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 8'h22,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h23,
  parameter logic [IDX_W-1:0] KEY_INDEX = 8'h13,
  parameter logic [DATA_W-1:0] KEY_VALUE = 8'hC5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output cfgStrobe_t        strb
);
  logic [IDX_W-1:0] idxQ;
  logic unlockedQ;
  logic hitIndex, hitData, keyWr;

  assign hitIndex = (busAddr == INDEX_ADDR);
  assign hitData  = (busAddr == DATA_ADDR);
  assign keyWr    = busWr && hitData && (idxQ == KEY_INDEX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      unlockedQ <= 1'b0;
    end else begin
      if (busWr && hitIndex) idxQ <= busWdata;
      if (keyWr) unlockedQ <= (busWdata == KEY_VALUE);
    end
  end

  always_comb begin
    strb.regWr  = busWr && hitData && unlockedQ && (idxQ != KEY_INDEX) && !isReadOnly(idxQ);
    strb.regIdx = idxQ;
    strb.wdata  = busWdata;
    strb.rdIdx  = busRd && hitIndex;
    strb.rdData = busRd && hitData;
    strb.curIdx = idxQ;
  end

  // R1: index follows a write to the index port
  a_r1_index_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && hitIndex) |=> (idxQ == $past(busWdata)));

  // R3: key write decides the lock state
  a_r3_key_decides: assert property (@(posedge clk) disable iff (!rstN)
    keyWr |=> (unlockedQ == ($past(busWdata) == KEY_VALUE)));

  // R4: the lock state only moves on a key write
  a_r4_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    !keyWr |=> $stable(unlockedQ));
endmodule

// File: rtl/cfgkey_regs.sv
module cfgkey_regs
  import cfgkey_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobe_t        strb,
  output logic [DATA_W-1:0] busRdata,
  output logic [FLAT_W-1:0] regsFlat,
  output logic              chgValid,
  output logic [IDX_W-1:0]  chgIndex
);
  logic [DATA_W-1:0] curSel, newSel, rdSel;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) q <= resetValue(MY_IDX);
      else if (strb.regWr && strb.regIdx == MY_IDX) q <= newSel;
    end
    assign regsFlat[g*DATA_W +: DATA_W] = q;

    // R6: masked-off bits never appear
    a_r6_mask_kept: assert property (@(posedge clk) disable iff (!rstN)
      (q & ~(writeMask(MY_IDX) | resetValue(MY_IDX))) == '0);

    if (isReadOnly(MY_IDX)) begin : g_ro
      // R5: read-only registers keep their value
      a_r5_read_only: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> $stable(q));
    end
    if (MY_IDX == STICKY_IDX) begin : g_sticky
      // R7: set bits stay set, low nibble frozen
      a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> ((($past(q) & q) == $past(q)) && (q[3:0] == $past(q[3:0]))));
    end
  end

  assign curSel = regsFlat[strb.regIdx*DATA_W +: DATA_W];
  assign newSel = mergeWrite(strb.regIdx, curSel, strb.wdata);
  assign rdSel  = regsFlat[strb.curIdx*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata <= '0;
      chgValid <= 1'b0;
      chgIndex <= '0;
    end else begin
      if (strb.rdIdx) busRdata <= strb.curIdx;
      else if (strb.rdData) busRdata <= rdSel;
      chgValid <= strb.regWr && (newSel != curSel);
      if (strb.regWr) chgIndex <= strb.regIdx;
    end
  end

  // R3: the key register is never stored
  a_r3_key_not_stored: assert property (@(posedge clk) disable iff (!rstN)
    regsFlat[8'h13*DATA_W +: DATA_W] == '0);

  // R4: without a store strobe the bank is frozen
  a_r4_no_store: assert property (@(posedge clk) disable iff (!rstN)
    !strb.regWr |=> $stable(regsFlat));

  // R9: a change pulse is never held longer than one cycle without a new write
  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rstN)
    (chgValid && !strb.regWr) |=> !chgValid);
endmodule

// File: rtl/cfgkey_regfile.sv
module cfgkey_regfile
  import cfgkey_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 8'h22,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h23
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  output logic [2047:0]        regsFlat,
  output logic                 chgValid,
  output logic [7:0]           chgIndex
);
  cfgStrobe_t strb;

  cfgkey_ctrl #(
    .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .strb(strb)
  );

  cfgkey_regs regs_i (
    .clk(clk), .rstN(rstN), .strb(strb), .busRdata(busRdata),
    .regsFlat(regsFlat), .chgValid(chgValid), .chgIndex(chgIndex)
  );
endmodule

// File: tb/cfgkey_regfile_tb_top.sv
module cfgkey_regfile_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2047:0] regsFlat;
  logic chgValid;
  logic [7:0] chgIndex;

  int vecCount = 0, failCount = 0;
  logic [7:0] expReg [256];
  logic [7:0] expIdx;
  logic expUnl;

  always #5 clk = ~clk;

  cfgkey_regfile dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .regsFlat(regsFlat),
    .chgValid(chgValid), .chgIndex(chgIndex)
  );

  function automatic logic [7:0] mdlReset(input logic [7:0] i);
    case (i)
      8'h11: return 8'hF8;  8'h12: return 8'h20;
      8'h17: return 8'hFF;  8'h18: return 8'hF0;
      8'h1A: return 8'hFF;  8'h1B: return 8'hF0;
      8'h1D: return 8'hFF;  8'h20: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic mdlRo(input logic [7:0] i);
    return i inside {8'h30, 8'h34, 8'h35, 8'h3E, 8'h3F, 8'h46, 8'h4C, 8'h6A, 8'h73};
  endfunction

  function automatic logic [7:0] mdlMask(input logic [7:0] i);
    case (i)
      8'h1E: return 8'h07;  8'h12: return 8'hF7;
      8'h20: return 8'hBF;  8'h31: return 8'h21;
      8'h32: return 8'hC1;  8'h3C: return 8'h8F;
      8'h44: return 8'h3F;  8'h45: return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkBank(input string req);
    logic [2047:0] flat;
    for (int i = 0; i < 256; i++) flat[i*8 +: 8] = expReg[i];
    vecCount++;
    if (regsFlat !== flat) begin
      failCount++;
      for (int i = 0; i < 256; i++)
        if (regsFlat[i*8 +: 8] !== flat[i*8 +: 8]) begin
          $display("FAIL %s reg %0h actual=%0h expected=%0h", req, i, regsFlat[i*8 +: 8], flat[i*8 +: 8]);
          break;
        end
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    for (int i = 0; i < 256; i++) expReg[i] = mdlReset(8'(i));
    expIdx = 8'h00; expUnl = 1'b0;
  endtask

  // Write at address a; model update and checks of R4..R10
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic pulse;
    logic [7:0] nv;
    pulse = 1'b0;
    @(negedge clk); busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
    if (a == 8'h22) expIdx = d;
    else if (a == 8'h23) begin
      if (expIdx == 8'h13) expUnl = (d == 8'hC5);
      else if (expUnl && !mdlRo(expIdx)) begin
        if (expIdx == 8'h36) nv = expReg[expIdx] | (d & 8'hF0);
        else nv = d & mdlMask(expIdx);
        pulse = (nv != expReg[expIdx]);
        expReg[expIdx] = nv;
      end
    end
    checkBank("R10 bank after write (R4/R5/R6/R7)");
    check("R9 change pulse", {31'd0, chgValid}, {31'd0, pulse});
    if (pulse) check("R9 change index", {24'd0, chgIndex}, {24'd0, expIdx});
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0;
    if (a == 8'h22) check("R1 index readback", {24'd0, busRdata}, {24'd0, expIdx});
    else if (a == 8'h23) check("R2 data readback", {24'd0, busRdata}, {24'd0, expReg[expIdx]});
  endtask

  task automatic wrReg(input logic [7:0] idx, input logic [7:0] d);
    wr(8'h22, idx); wr(8'h23, d); rd(8'h23);
  endtask

  logic [7:0] pickList [12] = '{8'h12, 8'h13, 8'h1E, 8'h20, 8'h30, 8'h31,
                                8'h32, 8'h36, 8'h3C, 8'h44, 8'h73, 8'h45};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_0042));
    doReset();
    @(negedge clk);
    checkBank("R8 reset values");
    rd(8'h22);
    // R8: locked after reset, so this write is refused
    wrReg(8'h20, 8'h00);
    // R3: wrong key keeps it locked
    wrReg(8'h13, 8'hC4);
    wrReg(8'h20, 8'h00);
    // R3: correct key unlocks; 13h reads zero
    wrReg(8'h13, 8'hC5);
    check("R3 key reg reads 00", {24'd0, busRdata}, 32'h0);
    wrReg(8'h20, 8'hFF);   // R6 mask BFh
    wrReg(8'h12, 8'hFF);   // R6 mask F7h
    wrReg(8'h1E, 8'hFF);   // R6 mask 07h
    wrReg(8'h30, 8'hFF);   // R5 read-only
    wrReg(8'h73, 8'hA5);   // R5 read-only
    wrReg(8'h36, 8'h5A);   // R7 sticky
    wrReg(8'h36, 8'hA5);   // R7 OR accumulates
    wrReg(8'h36, 8'h00);   // R7 clear attempt, no pulse
    wrReg(8'h55, 8'h3C);
    wrReg(8'h55, 8'h3C);   // R9 same value: no pulse
    wrReg(8'h13, 8'h00);   // R3 relock
    wrReg(8'h55, 8'h00);   // R4 refused
    wrReg(8'h13, 8'hC5);
    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      logic [7:0] v;
      r = $urandom_range(0, 9);
      v = 8'($urandom);
      if (r < 3) wr(8'h22, ($urandom_range(0, 1) != 0) ? pickList[$urandom_range(0, 11)] : v);
      else if (r < 6) wr(8'h23, ($urandom_range(0, 7) == 0) ? 8'hC5 : v);
      else if (r < 8) rd(8'h23);
      else if (r < 9) rd(8'h22);
      else if ($urandom_range(0, 19) == 0) begin
        doReset(); @(negedge clk); checkBank("R8 reset values");
      end else wr(8'h22, 8'h13);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule